// File: doc/BRIEF.md
# Multi-Format Audio Serial Port

This block is the slave side of a stereo serial audio link. An external bit clock and frame clock pace the link. One serial data input carries a left/right sample pair into the chip, and one serial data output carries a pair back out. The block runs on its own system clock and oversamples all three link inputs through a small synchronizer. It acts on the detected bit-clock edges: input bits are taken on rising edges, and output bits are launched after falling edges.

A two-bit format code selects the framing. Receive and transmit framings are not always the same. Codes 0 and 1 receive right-justified words of 16 and 24 bits and transmit 24-bit left-justified words. Code 2 is 24-bit left-justified in both directions. Code 3 is 24-bit I2S in both directions. Received pairs come out on two parallel buses with a one-cycle strobe. Transmit words are taken from two parallel buses at the start of every left slot, and a one-cycle strobe marks that moment.

Top module: `audio_serial_port`

## Requirements
- R1: The format code is fixed per session. 0 means receive 16-bit right-justified, 1 means receive 24-bit right-justified, 2 means 24-bit left-justified, and 3 means I2S. For codes 0 to 2 the left channel occupies the slot in which the frame clock is high. For code 3 the left channel occupies the slot in which the frame clock is low.
- R2: In code 0 the received word is the last 16 bits clocked in before the frame-clock edge that closes the slot, MSB first. It is delivered in bits 23:8 with bits 7:0 zero. Earlier bits of the slot are ignored.
- R3: In code 1 the received word is the last 24 bits clocked in before the closing frame-clock edge, MSB first. Earlier bits are ignored.
- R4: In code 2 the received MSB is the bit taken on the first bit-clock rise after a frame-clock change, followed by 23 more bits. Any later bits of the slot are ignored.
- R5: In code 3 the received MSB is the bit taken on the second bit-clock rise after a frame-clock change. This holds also when a slot is only 24 bit clocks long, in which case the LSB falls on the first rise of the following slot.
- R6: Once the right word is complete, rx_left_o and rx_right_o present the pair and rx_valid_o is high for exactly one cycle. Only pairs whose left and right slots both started after the first frame-clock change since reset or enable are delivered.
- R7: For codes 0 to 2, sdout_o carries the 24-bit word MSB first, starting after the falling bit-clock edge at which the frame clock changes. After the word it stays low for the rest of the slot.
- R8: For code 3, sdout_o carries the MSB after the second falling edge of the slot, so the first bit position holds the previous word's leftover bit or low. After the word it stays low.
- R9: At the falling edge that opens a left slot, tx_left_i and tx_right_i are both captured and tx_load_o pulses once. Changes to the inputs later in the frame do not alter the word sent in the right slot.
- R10: sdout_o is low while rst is high or port_en is low. It stays low until the first frame-clock change after enable.
- R11: Code 0 also works with 16 bit clocks per slot. The full 16-bit receive word is taken, and the 16 most significant transmit bits are sent.
- R12: sdout_o changes only in the cycle after a detected falling bit-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, fast enough to oversample the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Port enable; low holds the port cleared |
| fmt_i | input | 2 | Framing code 0..3 |
| bclk_i | input | 1 | External bit clock |
| lrck_i | input | 1 | External frame (channel) clock |
| sdin_i | input | 1 | Serial data input |
| tx_left_i | input | 24 | Left word to transmit |
| tx_right_i | input | 24 | Right word to transmit |
| sdout_o | output | 1 | Serial data output |
| tx_load_o | output | 1 | One-cycle pulse when transmit words are captured |
| rx_left_o | output | 24 | Last received left word |
| rx_right_o | output | 24 | Last received right word |
| rx_valid_o | output | 1 | One-cycle strobe for a new received pair |

## Verification
Each code is driven with random words and with slot lengths of 32 and 24 bit clocks. Code 0 is also driven with 16-bit slots. Filler bits outside the word are driven high, so a window placed one bit early or late corrupts the received word instead of passing unnoticed. The 24-bit I2S case separates a design that carries the LSB across the frame-clock edge from one that drops it. The transmit words are scrambled halfway through each left slot, which shows whether the right word was captured at frame start or read live.

// File: rtl/asp_pkg.sv
package asp_pkg;

    typedef enum logic [1:0] {
        FMT_RJ16 = 2'd0,
        FMT_RJ24 = 2'd1,
        FMT_LJ24 = 2'd2,
        FMT_I2S  = 2'd3
    } asp_fmt_e;

    // Link activity seen in the system clock domain
    typedef struct packed {
        logic rise;
        logic fall;
        logic lr;
        logic sd;
    } asp_evt_t;

    // Frame-clock level that marks the left slot
    function automatic logic left_level(asp_fmt_e f);
        return (f != FMT_I2S);
    endfunction

    function automatic logic is_i2s(asp_fmt_e f);
        return (f == FMT_I2S);
    endfunction

endpackage

// File: rtl/asp_edge_sync.sv
module asp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            clr,
    input  logic            bclk_i,
    input  logic            lrck_i,
    input  logic            sdin_i,
    output asp_pkg::asp_evt_t evt_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][2:0] stg;
    logic                   bclk_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (clr) stg <= '0;
                else     stg[0] <= {bclk_i, lrck_i, sdin_i};
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (clr) stg <= '0;
                else     stg <= {stg[STAGES-2:0], {bclk_i, lrck_i, sdin_i}};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (clr) bclk_q <= 1'b0;
        else     bclk_q <= stg[LAST][2];
    end

    always_comb begin
        evt_o.rise = stg[LAST][2] & ~bclk_q;
        evt_o.fall = ~stg[LAST][2] & bclk_q;
        evt_o.lr   = stg[LAST][1];
        evt_o.sd   = stg[LAST][0];
    end

endmodule

// File: rtl/asp_rx_deser.sv
module asp_rx_deser
    import asp_pkg::*;
#(
    parameter int WORD_W  = 24,
    parameter int SHORT_W = 16,
    parameter int CNT_W   = 7
) (
    input  logic              clk,
    input  logic              clr,
    input  asp_fmt_e          fmt,
    input  logic              rise,
    input  logic              lr,
    input  logic              sd,
    output logic [WORD_W-1:0] rx_left,
    output logic [WORD_W-1:0] rx_right,
    output logic              rx_valid
);
    localparam int               PAD_W = WORD_W - SHORT_W;
    localparam logic [CNT_W-1:0] W_CNT = CNT_W'(WORD_W);

    logic              seen, lr_prev, locked, pend, pend_left, have_left;
    logic [CNT_W-1:0]  cnt, idx;
    logic [WORD_W-1:0] sh, left_hold, cap_word;
    logic              change, shift_en, cap, cap_left, ended_left;

    always_comb begin
        change     = seen && (lr != lr_prev);
        idx        = change ? '0 : ((&cnt) ? cnt : cnt + 1'b1);
        ended_left = (lr_prev == left_level(fmt));
        unique case (fmt)
            FMT_RJ16, FMT_RJ24: shift_en = 1'b1;
            FMT_LJ24:           shift_en = (idx < W_CNT);
            default:            shift_en = (idx != '0 && idx <= W_CNT)
                                        || (change && cnt == W_CNT - 1'b1);
        endcase
        if (is_i2s(fmt)) begin
            cap      = pend && !change;
            cap_left = pend_left;
        end else begin
            cap      = change && locked;
            cap_left = ended_left;
        end
        if (fmt == FMT_RJ16) cap_word = {sh[SHORT_W-1:0], {PAD_W{1'b0}}};
        else                 cap_word = sh;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            seen      <= 1'b0;
            lr_prev   <= 1'b0;
            locked    <= 1'b0;
            pend      <= 1'b0;
            pend_left <= 1'b0;
            have_left <= 1'b0;
            cnt       <= '1;
            sh        <= '0;
            left_hold <= '0;
            rx_left   <= '0;
            rx_right  <= '0;
            rx_valid  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (rise) begin
                lr_prev <= lr;
                if (!seen) begin
                    seen <= 1'b1;
                end else begin
                    cnt <= idx;
                    if (shift_en) sh <= {sh[WORD_W-2:0], sd};
                    if (change) locked <= 1'b1;
                    pend      <= change && locked && is_i2s(fmt);
                    pend_left <= change ? ended_left : pend_left;
                    if (cap) begin
                        if (cap_left) begin
                            left_hold <= cap_word;
                            have_left <= 1'b1;
                        end else if (have_left) begin
                            rx_left   <= left_hold;
                            rx_right  <= cap_word;
                            rx_valid  <= 1'b1;
                            have_left <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (clr)
        rx_valid |=> !rx_valid);

    assert_short_pad_R2: assert property (@(posedge clk) disable iff (clr)
        (rx_valid && fmt == FMT_RJ16) |->
            (rx_left[PAD_W-1:0] == '0 && rx_right[PAD_W-1:0] == '0));

endmodule

// File: rtl/asp_tx_ser.sv
module asp_tx_ser
    import asp_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              clr,
    input  asp_fmt_e          fmt,
    input  logic              fall,
    input  logic              lr,
    input  logic [WORD_W-1:0] tx_left_i,
    input  logic [WORD_W-1:0] tx_right_i,
    output logic              sdout,
    output logic              tx_load
);
    logic              seen, lr_prev, change, new_left;
    logic [WORD_W-1:0] sh, right_hold, word;

    always_comb begin
        change   = seen && (lr != lr_prev);
        new_left = (lr == left_level(fmt));
        word     = new_left ? tx_left_i : right_hold;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            seen       <= 1'b0;
            lr_prev    <= 1'b0;
            sh         <= '0;
            right_hold <= '0;
            sdout      <= 1'b0;
            tx_load    <= 1'b0;
        end else begin
            tx_load <= 1'b0;
            if (fall) begin
                lr_prev <= lr;
                if (!seen) begin
                    seen <= 1'b1;
                end else if (change) begin
                    if (new_left) begin
                        right_hold <= tx_right_i;
                        tx_load    <= 1'b1;
                    end
                    if (is_i2s(fmt)) begin
                        sdout <= sh[WORD_W-1];
                        sh    <= word;
                    end else begin
                        sdout <= word[WORD_W-1];
                        sh    <= {word[WORD_W-2:0], 1'b0};
                    end
                end else begin
                    sdout <= sh[WORD_W-1];
                    sh    <= {sh[WORD_W-2:0], 1'b0};
                end
            end
        end
    end

    assert_sdout_quiet_R10: assert property (@(posedge clk)
        clr |=> !sdout);

    assert_sdout_on_fall_R12: assert property (@(posedge clk) disable iff (clr)
        !fall |=> $stable(sdout));

    assert_load_left_R9: assert property (@(posedge clk) disable iff (clr)
        tx_load |-> (lr_prev == left_level(fmt)));

endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port #(
    parameter int WORD_W      = 24,
    parameter int SHORT_W     = 16,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_en,
    input  logic [1:0]        fmt_i,
    input  logic              bclk_i,
    input  logic              lrck_i,
    input  logic              sdin_i,
    input  logic [WORD_W-1:0] tx_left_i,
    input  logic [WORD_W-1:0] tx_right_i,
    output logic              sdout_o,
    output logic              tx_load_o,
    output logic [WORD_W-1:0] rx_left_o,
    output logic [WORD_W-1:0] rx_right_o,
    output logic              rx_valid_o
);
    import asp_pkg::*;

    logic     clr;
    asp_fmt_e fmt;
    asp_evt_t evt;

    assign clr = rst | ~port_en;
    assign fmt = asp_fmt_e'(fmt_i);

    asp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .clr    (clr),
        .bclk_i (bclk_i),
        .lrck_i (lrck_i),
        .sdin_i (sdin_i),
        .evt_o  (evt)
    );

    asp_rx_deser #(.WORD_W(WORD_W), .SHORT_W(SHORT_W), .CNT_W(CNT_W)) u_rx (
        .clk      (clk),
        .clr      (clr),
        .fmt      (fmt),
        .rise     (evt.rise),
        .lr       (evt.lr),
        .sd       (evt.sd),
        .rx_left  (rx_left_o),
        .rx_right (rx_right_o),
        .rx_valid (rx_valid_o)
    );

    asp_tx_ser #(.WORD_W(WORD_W)) u_tx (
        .clk        (clk),
        .clr        (clr),
        .fmt        (fmt),
        .fall       (evt.fall),
        .lr         (evt.lr),
        .tx_left_i  (tx_left_i),
        .tx_right_i (tx_right_i),
        .sdout      (sdout_o),
        .tx_load    (tx_load_o)
    );

endmodule

// File: tb/audio_serial_port_tb.sv
module audio_serial_port_tb;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        port_en = 1'b0;
    logic [1:0]  fmt_i = 2'd3;
    logic        bclk_i = 1'b1;
    logic        lrck_i = 1'b1;
    logic        sdin_i = 1'b0;
    logic [23:0] tx_left_i = '0;
    logic [23:0] tx_right_i = '0;
    logic        sdout_o, tx_load_o, rx_valid_o;
    logic [23:0] rx_left_o, rx_right_o;

    int checks = 0;
    int errors = 0;
    int load_cnt = 0;
    string rx_tag = "R6";
    logic [47:0] rxq[$];

    always #2 clk = ~clk;

    audio_serial_port u_dut (
        .clk(clk), .rst(rst), .port_en(port_en), .fmt_i(fmt_i),
        .bclk_i(bclk_i), .lrck_i(lrck_i), .sdin_i(sdin_i),
        .tx_left_i(tx_left_i), .tx_right_i(tx_right_i),
        .sdout_o(sdout_o), .tx_load_o(tx_load_o),
        .rx_left_o(rx_left_o), .rx_right_o(rx_right_o), .rx_valid_o(rx_valid_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: scoreboard pop on every received pair
    always @(negedge clk) begin
        if (tx_load_o) load_cnt++;
        if (rx_valid_o) begin
            if (rxq.size() == 0) begin
                check(1'b0, {rx_tag, " unexpected pair"}, {16'h0, rx_left_o, rx_right_o}, 64'h0);
            end else begin
                logic [47:0] e;
                e = rxq.pop_front();
                check({rx_left_o, rx_right_o} == e, rx_tag, {16'h0, rx_left_o, rx_right_o}, {16'h0, e});
            end
        end
    end

    function automatic logic rx_bit(int f, int len, int plen, int i, logic [23:0] w, logic [23:0] pw);
        int k;
        k = -1;
        case (f)
            0: k = (i >= len - 16) ? 23 - (i - (len - 16)) : -1;
            1: k = (i >= len - 24) ? 23 - (i - (len - 24)) : -1;
            2: k = (i < 24) ? 23 - i : -1;
            default: begin
                if (i == 0) return (plen == 24) ? pw[0] : 1'b1;
                k = (i <= 24) ? 24 - i : -1;
            end
        endcase
        if (k < 0 || k > 23) return 1'b1;   // filler, must be ignored
        return w[k];
    endfunction

    function automatic logic tx_bit(int f, int plen, int i, logic [23:0] w, logic [23:0] pw);
        if (f == 3) begin
            if (i == 0) return (plen == 24) ? pw[0] : 1'b0;
            return (i <= 24) ? w[24 - i] : 1'b0;
        end
        return (i < 24) ? w[23 - i] : 1'b0;
    endfunction

    task automatic half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic send_slot(input int f, input int len, input int plen, input logic lvl,
                             input logic [23:0] rxw, input logic [23:0] prx,
                             input logic [23:0] txw, input logic [23:0] ptx,
                             input bit chk, input bit scramble, input string tag);
        logic [63:0] got, exp;
        got = '0;
        exp = '0;
        for (int i = 0; i < len; i++) begin
            bclk_i = 1'b0;
            lrck_i = lvl;
            sdin_i = rx_bit(f, len, plen, i, rxw, prx);
            if (scramble && i == len / 2) begin
                tx_left_i  = $urandom();
                tx_right_i = $urandom();
            end
            half();
            got[i] = sdout_o;
            exp[i] = tx_bit(f, plen, i, txw, ptx);
            bclk_i = 1'b1;
            half();
        end
        if (chk) check(got == exp, tag, got, exp);
    endtask

    task automatic run(input int f, input int len, input int frames, input string rtag, input string ttag);
        logic lvl;
        logic [23:0] prx, ptx, l, r, tl, tr;
        port_en = 1'b0;
        fmt_i = f[1:0];
        lrck_i = (f != 3) ? 1'b0 : 1'b1;
        bclk_i = 1'b1;
        repeat (4) @(negedge clk);
        check(sdout_o == 1'b0 && rx_valid_o == 1'b0, "R10 disabled", {62'h0, sdout_o, rx_valid_o}, 64'h0);
        rx_tag = rtag;
        load_cnt = 0;
        port_en = 1'b1;
        repeat (4) @(negedge clk);
        lvl = (f != 3);
        // Preamble in the right slot: no lock yet, output stays low (R10)
        send_slot(f, 10, 10, ~lvl, 24'h0, 24'h0, 24'h0, 24'h0, 1'b1, 1'b0, "R10 before lock");
        prx = '0;
        ptx = '0;
        for (int n = 0; n < frames; n++) begin
            l  = $urandom();
            r  = $urandom();
            if (f == 0) begin
                l[7:0] = 8'h0;
                r[7:0] = 8'h0;
            end
            tl = $urandom();
            tr = $urandom();
            tx_left_i  = tl;
            tx_right_i = tr;
            rxq.push_back({l, r});
            send_slot(f, len, (n == 0) ? 10 : len, lvl, l, prx, tl, ptx, 1'b1, 1'b1, {ttag, " left"});
            send_slot(f, len, len, ~lvl, r, l, tr, tl, 1'b1, 1'b0, {ttag, " R9 right"});
            prx = r;
            ptx = tr;
        end
        send_slot(f, 4, len, lvl, 24'h0, prx, 24'h0, ptx, 1'b0, 1'b0, "flush");
        repeat (40) @(negedge clk);
        check(rxq.size() == 0, {rtag, " pairs missing"}, rxq.size(), 0);
        check(load_cnt == frames + 1, "R9 load pulses", load_cnt, frames + 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(sdout_o == 1'b0 && rx_valid_o == 1'b0 && tx_load_o == 1'b0,
              "R10 reset", {61'h0, sdout_o, rx_valid_o, tx_load_o}, 64'h0);
        rst = 1'b0;
        run(3, 32, 3, "R5 R1 R6", "R8 R12");
        run(3, 24, 2, "R5 24-bit slot", "R8 24-bit slot");
        run(0, 32, 2, "R2 R1", "R7 R12");
        run(0, 16, 2, "R11 R2", "R11 R7");
        run(1, 32, 2, "R3", "R7");
        run(1, 24, 1, "R3 24-bit slot", "R7 24-bit slot");
        run(2, 32, 2, "R4", "R7");
        run(2, 24, 1, "R4 24-bit slot", "R7 24-bit slot");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule